// File: doc/BRIEF.md
# Smart-Card Command Transmit Sequencer with Instruction Echo Check

This block drives the transmit side of a smart-card link. It sends a command that sits in a byte buffer, and each byte goes out as nine bits: eight data bits and one parity bit. Between bytes it leaves a fixed gap. When the command has been sent, the block waits for the card's first answer byte. An external serial transmitter does the bit timing: it receives a start strobe together with the byte and the parity bit, and it reports back with a done strobe. The receiver returns incoming bytes through a valid strobe and a data bus.

The block has a second, guarded mode. In this mode it sends only the five-byte command header. It then waits for the card to echo the instruction byte, which is the byte at buffer index 1, and it allows a limited number of slow ticks for that echo. If the echo arrives and matches, the block pauses for a fixed time and then sends the rest of the command. If no byte arrives before the tick limit, the block gives up. If a different byte arrives, the block stops sending and passes that byte out on an inject strobe, so that the response buffer stores it as the start of the card's answer.

Every transfer ends with a one-cycle done pulse and a result code. The result code stays unchanged until the next transfer ends.

Top module: `card_tx_sequencer`

## Requirements
- R1: Every byte is presented on `tx_data_o` with `tx_start_o` high for one cycle. In that same cycle, `tx_par_o` equals the XOR of the eight data bits, which gives even parity over all nine bits.
- R2: With `confirm_i`=0, the bytes at buffer indices 0 to `len_i`-1 are sent in index order. The block then waits for a received byte before it signals done with result 0.
- R3: The next `tx_start_o` pulse is high exactly GAP_CYC+3 clock cycles after the cycle in which `tx_done_i` is high. This holds for every byte that is not the first byte after an echo pause.
- R4: With `confirm_i`=1 and `len_i`>=5, buffer byte 1 is stored as the expected echo. Bytes 0 to 4 are sent, and then the block waits for a received byte.
- R5: If no byte arrives within TIMEOUT_TICKS pulses of `tick_i` after the header, the block ends with result 1. No further byte is sent.
- R6: If the byte received after the header differs from the expected echo, the block ends with result 2. No further byte is sent. `inj_valid_o` pulses together with `done_o` and carries the received byte on `inj_data_o`.
- R7: If the echo matches, the first remaining byte starts exactly PAUSE_CYC+4 cycles after the cycle in which `rx_valid_i` carries the echo. The remaining bytes are then sent, and the block waits for a reply byte and ends with result 0.
- R8: With `confirm_i`=1 and 1<=`len_i`<5, all bytes are sent in order with no echo check. The block waits for a reply byte and ends with result 0.
- R9: A start with `len_i`=0 sends nothing. It raises `done_o` in the cycle right after the start, with result 0.
- R10: Each transfer gives exactly one `done_o` pulse, one cycle long. After the done pulse the block is idle. A `start_i` pulse that arrives while `busy_o` is high has no effect. Out of reset the block is idle and all strobes are low.
- R11: `status_o` changes only in a cycle where `done_o` is high. Its codes are 0 for complete, 1 for no echo and 2 for a wrong echo.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to send the buffered command |
| confirm_i | input | 1 | 1 selects the header/echo mode, sampled at start |
| len_i | input | LEN_W | Number of bytes in the buffer, sampled at start |
| buf_addr_o | output | ADDR_W | Buffer read address, registered |
| buf_rdata_i | input | 8 | Buffer read data, one cycle after the address |
| tx_data_o | output | 8 | Byte for the serial transmitter |
| tx_par_o | output | 1 | Ninth (parity) bit for the transmitter |
| tx_start_o | output | 1 | One-cycle strobe that starts a byte |
| tx_done_i | input | 1 | Transmitter finished the current byte |
| rx_valid_i | input | 1 | A byte has been received from the card |
| rx_data_i | input | 8 | Received byte |
| tick_i | input | 1 | Slow timebase pulse for the echo timeout |
| busy_o | output | 1 | A transfer is in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| status_o | output | 2 | Result of the last transfer |
| inj_valid_o | output | 1 | Push `inj_data_o` into the response buffer |
| inj_data_o | output | 8 | Wrong echo byte kept as the card's answer |

## Verification
The hardest case to reach is the exact cycle relation around the echo. This covers the pause that follows a matching echo, the timeout window when no echo comes, and the wrong byte that must come out on the inject strobe rather than being lost. The bench models both the serial transmitter and a card. The card model is armed to answer a fixed number of cycles after a chosen count of transmit-done strobes, with the correct instruction byte, a corrupted byte, or no byte at all. The sweep covers every length from 0 to 9 in both modes, for two buffer contents. It measures every gap, the pause and the timeout against counts derived from the parameters. A stray start pulse is injected while each longer transfer is busy.

// File: rtl/card_tx_pkg.sv
`timescale 1ns/1ps
package card_tx_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ECHO_FETCH,
    ST_ECHO_LOAD,
    ST_FETCH,
    ST_LOAD,
    ST_WAIT_TX,
    ST_GAP,
    ST_ECHO_WAIT,
    ST_PAUSE,
    ST_REPLY_WAIT
  } seq_state_t;

  typedef enum logic [1:0] {
    RES_OK       = 2'd0,
    RES_NO_ECHO  = 2'd1,
    RES_BAD_ECHO = 2'd2
  } seq_result_t;
endpackage

// File: rtl/card_tx_interval.sv
`timescale 1ns/1ps
// Loadable down-counter; expire_o is high in the last cycle of the interval.
module card_tx_interval #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] value_i,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load_i)        cnt_q <= value_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - W'(1);
  end

  assign expire_o = (cnt_q == W'(1));
endmodule

// File: rtl/card_tx_tick_timer.sv
`timescale 1ns/1ps
// Counts slow ticks after a load; expire_o flags the final tick.
module card_tx_tick_timer #(
  parameter int TICKS = 65
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int W = $clog2(TICKS + 1);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                          cnt_q <= '0;
    else if (load_i)                  cnt_q <= W'(TICKS);
    else if (tick_i && cnt_q != '0)   cnt_q <= cnt_q - W'(1);
  end

  assign expire_o = tick_i && (cnt_q == W'(1));
endmodule

// File: rtl/card_tx_framer.sv
`timescale 1ns/1ps
// Registers the outgoing byte with its ninth (even parity) bit and a start strobe.
module card_tx_framer #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [DW-1:0] byte_i,
  output logic [DW-1:0] tx_data_o,
  output logic          tx_par_o,
  output logic          tx_start_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_data_o  <= '0;
      tx_par_o   <= 1'b0;
      tx_start_o <= 1'b0;
    end else begin
      tx_start_o <= load_i;
      if (load_i) begin
        tx_data_o <= byte_i;
        tx_par_o  <= ^byte_i;
      end
    end
  end
endmodule

// File: rtl/card_tx_sequencer.sv
`timescale 1ns/1ps
module card_tx_sequencer
  import card_tx_pkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter int LEN_W         = ADDR_W + 1,
  parameter int GAP_CYC       = 24,
  parameter int PAUSE_CYC     = 96,
  parameter int TIMEOUT_TICKS = 65,
  parameter int HDR_LEN       = 5,
  parameter int ECHO_IDX      = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              confirm_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [ADDR_W-1:0] buf_addr_o,
  input  logic [7:0]        buf_rdata_i,
  output logic [7:0]        tx_data_o,
  output logic              tx_par_o,
  output logic              tx_start_o,
  input  logic              tx_done_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  input  logic              tick_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        status_o,
  output logic              inj_valid_o,
  output logic [7:0]        inj_data_o
);
  localparam int IV_MAX = (GAP_CYC > PAUSE_CYC) ? GAP_CYC : PAUSE_CYC;
  localparam int IV_W   = $clog2(IV_MAX + 1);

  seq_state_t        state_q;
  logic [LEN_W-1:0]  len_q, sent_q;
  logic [ADDR_W-1:0] addr_q;
  logic              confirm_q;
  logic [7:0]        expect_q, rx_byte_q;
  logic              rx_seen_q;
  logic              done_q, inj_valid_q;
  logic [1:0]        status_q;
  logic [7:0]        inj_data_q;

  logic            load_byte, iv_load, iv_exp, tmo_load, tmo_exp;
  logic [IV_W-1:0] iv_val;
  logic            hdr_sent, all_sent, echo_ok, rx_consume;

  assign load_byte  = (state_q == ST_LOAD);
  assign hdr_sent   = confirm_q && (sent_q == LEN_W'(HDR_LEN));
  assign all_sent   = (sent_q == len_q);
  assign echo_ok    = (rx_byte_q == expect_q);
  assign iv_load    = (state_q == ST_WAIT_TX && tx_done_i) ||
                      (state_q == ST_ECHO_WAIT && rx_seen_q && echo_ok);
  assign iv_val     = (state_q == ST_WAIT_TX) ? IV_W'(GAP_CYC) : IV_W'(PAUSE_CYC);
  assign tmo_load   = (state_q == ST_GAP) && iv_exp && hdr_sent;
  assign rx_consume = load_byte ||
                      (rx_seen_q && (state_q == ST_ECHO_WAIT || state_q == ST_REPLY_WAIT));

  card_tx_interval #(.W(IV_W)) u_interval (
    .clk(clk), .rst(rst), .load_i(iv_load), .value_i(iv_val), .expire_o(iv_exp)
  );

  card_tx_tick_timer #(.TICKS(TIMEOUT_TICKS)) u_timeout (
    .clk(clk), .rst(rst), .load_i(tmo_load), .tick_i(tick_i), .expire_o(tmo_exp)
  );

  card_tx_framer #(.DW(8)) u_framer (
    .clk(clk), .rst(rst), .load_i(load_byte), .byte_i(buf_rdata_i),
    .tx_data_o(tx_data_o), .tx_par_o(tx_par_o), .tx_start_o(tx_start_o)
  );

  // Latest received byte, with a flag consumed by the wait states.
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_seen_q <= 1'b0;
      rx_byte_q <= '0;
    end else if (rx_valid_i) begin
      rx_seen_q <= 1'b1;
      rx_byte_q <= rx_data_i;
    end else if (rx_consume) begin
      rx_seen_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      len_q       <= '0;
      sent_q      <= '0;
      addr_q      <= '0;
      confirm_q   <= 1'b0;
      expect_q    <= '0;
      done_q      <= 1'b0;
      status_q    <= RES_OK;
      inj_valid_q <= 1'b0;
      inj_data_q  <= '0;
    end else begin
      done_q      <= 1'b0;
      inj_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          len_q     <= len_i;
          confirm_q <= confirm_i;
          sent_q    <= '0;
          if (len_i == '0) begin
            done_q   <= 1'b1;
            status_q <= RES_OK;
          end else if (confirm_i) begin
            addr_q  <= ADDR_W'(ECHO_IDX);
            state_q <= ST_ECHO_FETCH;
          end else begin
            addr_q  <= '0;
            state_q <= ST_FETCH;
          end
        end
        ST_ECHO_FETCH: state_q <= ST_ECHO_LOAD;
        ST_ECHO_LOAD: begin
          expect_q <= buf_rdata_i;
          addr_q   <= '0;
          state_q  <= ST_FETCH;
        end
        ST_FETCH: state_q <= ST_LOAD;
        ST_LOAD: begin
          addr_q  <= addr_q + ADDR_W'(1);
          sent_q  <= sent_q + LEN_W'(1);
          state_q <= ST_WAIT_TX;
        end
        ST_WAIT_TX: if (tx_done_i) state_q <= ST_GAP;
        ST_GAP: if (iv_exp) begin
          if (hdr_sent)      state_q <= ST_ECHO_WAIT;
          else if (all_sent) state_q <= ST_REPLY_WAIT;
          else               state_q <= ST_FETCH;
        end
        ST_ECHO_WAIT: begin
          if (rx_seen_q) begin
            if (echo_ok) begin
              state_q <= ST_PAUSE;
            end else begin
              state_q     <= ST_IDLE;
              done_q      <= 1'b1;
              status_q    <= RES_BAD_ECHO;
              inj_valid_q <= 1'b1;
              inj_data_q  <= rx_byte_q;
            end
          end else if (tmo_exp) begin
            state_q  <= ST_IDLE;
            done_q   <= 1'b1;
            status_q <= RES_NO_ECHO;
          end
        end
        ST_PAUSE: if (iv_exp) state_q <= all_sent ? ST_REPLY_WAIT : ST_FETCH;
        ST_REPLY_WAIT: if (rx_seen_q) begin
          state_q  <= ST_IDLE;
          done_q   <= 1'b1;
          status_q <= RES_OK;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign buf_addr_o  = addr_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign status_o    = status_q;
  assign inj_valid_o = inj_valid_q;
  assign inj_data_o  = inj_data_q;
endmodule

// File: rtl/card_tx_sequencer_chk.sv
`timescale 1ns/1ps
module card_tx_sequencer_chk #(
  parameter int LEN_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic [LEN_W-1:0] len_i,
  input logic [7:0]       tx_data_o,
  input logic             tx_par_o,
  input logic             tx_start_o,
  input logic             tx_done_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [1:0]       status_o,
  input logic             inj_valid_o
);
  // R1
  parity_even_chk: assert property (@(posedge clk) disable iff (rst)
    tx_start_o |-> (tx_par_o == ^tx_data_o));

  // R3
  gap_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_done_i && busy_o) |=> !tx_start_o);

  // R6
  inject_on_bad_echo_chk: assert property (@(posedge clk) disable iff (rst)
    inj_valid_o |-> (done_o && status_o == 2'd2));

  // R9
  zero_len_done_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && len_i == '0) |=> (done_o && status_o == 2'd0 && !busy_o));

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R10
  idle_at_done_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  // R11
  status_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(status_o));
endmodule

bind card_tx_sequencer card_tx_sequencer_chk #(.LEN_W(LEN_W)) u_chk (.*);

// File: tb/card_tx_sequencer_tb.sv
`timescale 1ns/1ps
module card_tx_sequencer_tb;
  localparam int AW = 8, LW = 9;
  localparam int GAP = 6, PAUSE = 20, TMO = 65, ULAT = 12, TDIV = 4;

  logic clk = 1'b0, rst = 1'b1;
  always #2 clk = ~clk;

  logic          start_i = 0, confirm_i = 0;
  logic [LW-1:0] len_i = '0;
  logic [AW-1:0] buf_addr_o;
  logic [7:0]    buf_rdata_i = '0;
  logic [7:0]    tx_data_o, rx_data_i, inj_data_o;
  logic          tx_par_o, tx_start_o, tx_done_i, rx_valid_i, tick_i;
  logic          busy_o, done_o, inj_valid_o;
  logic [1:0]    status_o;

  card_tx_sequencer #(.ADDR_W(AW), .LEN_W(LW), .GAP_CYC(GAP), .PAUSE_CYC(PAUSE),
                      .TIMEOUT_TICKS(TMO)) u_dut (.*);

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int tests = 0, fails = 0, seed_g = 0;

  function automatic logic [7:0] bufv(int i, int s);
    return 8'((i * 29 + s * 71 + 3) % 256);
  endfunction

  initial forever begin
    @(posedge clk);
    buf_rdata_i <= bufv(int'(buf_addr_o), seed_g);
  end

  task automatic chk(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Transmitter and card model state
  int ntx, ndone_tx, ndone_pulse, ninj, uart_cnt;
  int last_done_cyc, last_rx_cyc, done_cyc, start_cyc;
  int par_bad, gap_bad, gap_act, pause_bad, pause_act;
  bit pause_next;
  logic [7:0] txlog [16];
  logic [1:0] last_status;
  logic [7:0] inj_val;
  bit r1_en, r1_run, r1_echo, r2_en, r2_run;
  int r1_after, r1_delay, r1_cnt, r2_after, r2_delay, r2_cnt;
  logic [7:0] r1_val, r2_val;

  initial begin
    tx_done_i = 0; rx_valid_i = 0; rx_data_i = 0; tick_i = 0;
    forever begin
      @(negedge clk);
      tx_done_i = 0; rx_valid_i = 0;
      tick_i = (cyc % TDIV == 0);
      if (r1_run) begin
        r1_cnt--;
        if (r1_cnt == 0) begin
          r1_run = 0; rx_valid_i = 1; rx_data_i = r1_val; last_rx_cyc = cyc;
          if (r1_echo) pause_next = 1;
        end
      end
      if (r2_run) begin
        r2_cnt--;
        if (r2_cnt == 0) begin
          r2_run = 0; rx_valid_i = 1; rx_data_i = r2_val; last_rx_cyc = cyc;
        end
      end
      if (tx_start_o) begin
        if (ntx < 16) txlog[ntx] = tx_data_o;
        if (tx_par_o != ^tx_data_o) par_bad++;
        if (pause_next) begin
          if (cyc - last_rx_cyc != PAUSE + 4) begin pause_bad++; pause_act = cyc - last_rx_cyc; end
          pause_next = 0;
        end else if (ntx > 0) begin
          if (cyc - last_done_cyc != GAP + 3) begin gap_bad++; gap_act = cyc - last_done_cyc; end
        end
        ntx++;
        uart_cnt = ULAT;
      end else if (uart_cnt > 0) begin
        uart_cnt--;
        if (uart_cnt == 0) begin
          tx_done_i = 1; last_done_cyc = cyc; ndone_tx++;
          if (r1_en && ndone_tx == r1_after) begin r1_en = 0; r1_run = 1; r1_cnt = r1_delay; end
          if (r2_en && ndone_tx == r2_after) begin r2_en = 0; r2_run = 1; r2_cnt = r2_delay; end
        end
      end
      if (done_o) begin ndone_pulse++; last_status = status_o; done_cyc = cyc; end
      if (inj_valid_o) begin ninj++; inj_val = inj_data_o; end
    end
  end

  // scen: 0 = reply / matching echo, 1 = wrong echo, 2 = no echo
  task automatic run_case(int s, bit conf, int len, int scen);
    int exp_n, exp_st, first_bad, el;
    string tag;
    @(negedge clk);
    seed_g = s;
    ntx = 0; ndone_tx = 0; ndone_pulse = 0; ninj = 0; uart_cnt = 0;
    par_bad = 0; gap_bad = 0; gap_act = 0; pause_bad = 0; pause_act = 0; pause_next = 0;
    last_rx_cyc = 0; done_cyc = 0;
    r1_en = 0; r1_run = 0; r1_echo = 0; r2_en = 0; r2_run = 0;
    if (conf && len >= 5) begin
      r1_en = 1; r1_after = 5; r1_delay = 12;
      r1_val = (scen == 1) ? (bufv(1, s) ^ 8'h5A) : bufv(1, s);
      r1_echo = (scen == 0);
      if (scen == 2) r1_en = 0;
      if (scen == 0) begin
        r2_en = 1; r2_after = len; r2_val = 8'h90;
        r2_delay = (len == 5) ? (12 + PAUSE + 20) : 10;
      end
    end else if (len > 0) begin
      r1_en = 1; r1_after = len; r1_delay = 10; r1_val = 8'h61;
    end
    exp_n  = (conf && len >= 5 && scen != 0) ? 5 : len;
    exp_st = (scen == 1) ? 2 : (scen == 2) ? 1 : 0;
    tag = !conf ? "R2" : (len >= 5) ? "R4" : "R8";

    @(negedge clk);
    start_i = 1; confirm_i = conf; len_i = LW'(len); start_cyc = cyc;
    @(negedge clk);
    start_i = 0;
    if (len >= 3) begin
      repeat (3) @(negedge clk);
      start_i = 1; len_i = LW'(1); confirm_i = !conf;   // R10 stray start while busy
      @(negedge clk);
      start_i = 0;
    end
    for (int w = 0; w < 3000 && ndone_pulse == 0; w++) @(negedge clk);
    repeat (60) @(negedge clk);

    chk(ndone_pulse == 1, "R10 one done pulse per transfer", ndone_pulse, 1);
    chk(ntx == exp_n, {tag, " byte count"}, ntx, exp_n);
    first_bad = -1;
    for (int i = exp_n - 1; i >= 0; i--) if (i < 16 && txlog[i] != bufv(i, s)) first_bad = i;
    chk(first_bad < 0, {tag, " byte order/content (index of first bad)"}, first_bad, -1);
    chk(int'(last_status) == exp_st, "R11 result code", int'(last_status), exp_st);
    chk(int'(status_o) == exp_st, "R11 result held after done", int'(status_o), exp_st);
    chk(par_bad == 0, "R1 parity bit", par_bad, 0);
    if (ntx >= 2 && !(conf && len == 6 && scen == 0))
      chk(gap_bad == 0, "R3 inter-byte gap", gap_act, GAP + 3);
    chk(ninj == ((scen == 1) ? 1 : 0), "R6 inject strobe count", ninj, (scen == 1) ? 1 : 0);
    if (scen == 1)
      chk(inj_val == (bufv(1, s) ^ 8'h5A), "R6 injected byte", int'(inj_val), int'(bufv(1, s) ^ 8'h5A));
    if (scen == 0 && conf && len > 5)
      chk(pause_bad == 0, "R7 echo pause", pause_act, PAUSE + 4);
    if (scen == 0 && len > 0)
      chk(done_cyc > last_rx_cyc, {tag, " done waits for reply byte"}, done_cyc, last_rx_cyc + 2);
    if (scen == 2) begin
      el = done_cyc - last_done_cyc;
      chk(el >= TMO * TDIV && el <= TMO * TDIV + 12, "R5 echo timeout window", el, TMO * TDIV);
    end
    if (len == 0)
      chk(done_cyc - start_cyc == 1, "R9 zero length completes at once", done_cyc - start_cyc, 1);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (cyc > 150000) begin
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!busy_o && !done_o && !tx_start_o && !inj_valid_o, "R10 idle after reset",
        int'({busy_o, done_o, tx_start_o, inj_valid_o}), 0);
    chk(status_o == 2'd0, "R11 reset result code", int'(status_o), 0);
    for (int s = 0; s < 2; s++) begin
      for (int len = 0; len < 10; len++) begin
        run_case(s, 1'b0, len, 0);
        run_case(s, 1'b1, len, 0);
        if (len >= 5) begin
          run_case(s, 1'b1, len, 1);
          run_case(s, 1'b1, len, 2);
        end
      end
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule